// File: doc/BRIEF.md
# Bus-Style Master/Slave Access Handshake Controller

This controller lets components built for a plain shared bus reach slave components without any knowledge of packets. Each master starts with a request code, then gives a slave address, and finally gets a grant. The controller acknowledges each of these steps on a per-master reply code. When the grant is given, the master's outgoing control and data buses are steered to the chosen slave, and that slave's return buses are steered back to the master. The channel stays open until the master sends an end-of-communication code.

A grant needs two conditions. The addressed slave must report itself free on its status input, and no other master may hold that slave. Masters that wait on the same slave are served in rotating order, kept separately for each slave. Masters on different slaves can hold their channels at the same time. When no channel is open, the routed outputs are driven to zero.

Top module: `bus_access_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every reply code is 00 and every routed output bus (`s_ctl_out`, `s_dat_out`, `m_ctl_out`, `m_dat_out`) is zero.
- R2: A master in the idle state (reply 00) moves to reply 01 (request acknowledged) one clock after it presents request code 01. Request codes 00, 10 and 11 leave it at 00.
- R3: A master at reply 01 moves to reply 10 (address received) one clock after it presents an address with bit 0 set and slave code bits [3:1] below 4. It stays at 01 if bit 0 is clear or if the slave code is 4 to 7.
- R4: A master at reply 10 moves to reply 11 (granted) only when the addressed slave's `s_busy` bit is 0 and no other master holds that slave. Otherwise it stays at 10. Masters addressing different slaves may hold their grants at the same time.
- R5: If several masters wait at reply 10 for the same slave, the grant goes to the first waiting master after the one last granted that slave, counting upward by index with wrap-around. Master 0 has first priority after reset.
- R6: While a master is at reply 11, the slave it addressed drives out that master's control and data inputs, and the master drives out that slave's control and data inputs. A slave with no holder drives zeros, and a master that is not granted drives zeros.
- R7: Request code 10 (end of communication) at reply 01, 10 or 11 returns the master to 00 on the next clock. This takes priority over address capture and over the grant. A slave released this way may be granted to another master one clock later.
- R8: Asserting `rst` in any state returns every master to reply 00 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_req | input | 2*NM | Request code per master: 01 access, 10 end of communication |
| m_addr | input | AW*NM | Per master: bit 0 address valid, bits [AW-1:1] slave code |
| m_ack | output | 2*NM | Reply code per master: 00 idle, 01 request ack, 10 address ack, 11 grant |
| m_ctl_in | input | CW*NM | Control bus from each master |
| m_dat_in | input | DW*NM | Data bus from each master |
| m_ctl_out | output | CW*NM | Control bus returned to each master from its slave |
| m_dat_out | output | DW*NM | Data bus returned to each master from its slave |
| s_busy | input | NS | Slave status: 1 busy, 0 free |
| s_ctl_in | input | CW*NS | Control bus from each slave |
| s_dat_in | input | DW*NS | Data bus from each slave |
| s_ctl_out | output | CW*NS | Control bus to each slave from its holder |
| s_dat_out | output | DW*NS | Data bus to each slave from its holder |

## Verification
The bench aims at a second master that addresses a slave already held. A controller that ignores holders would give both masters the same slave, and one master's data would be lost. It also drives a release and a waiting master in back-to-back cycles. A wrong design here would grant in the same cycle as the end code, or stall one cycle too many. Other targets are slave codes above three and addresses without the valid flag, where a faulty design would accept a slave that does not exist. Three masters contend for one slave to show that rotation is used and not a fixed lowest-index rule. A long constrained-random phase then compares reply codes and both routing directions against a reference model in the bench on every cycle.

// File: rtl/bus_access_ctrl.sv
module bus_access_ctrl #(
  parameter int NM = 3,
  parameter int NS = 4,
  parameter int AW = 4,
  parameter int CW = 4,
  parameter int DW = 16
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [2*NM-1:0]  m_req,
  input  logic [AW*NM-1:0] m_addr,
  output logic [2*NM-1:0]  m_ack,
  input  logic [CW*NM-1:0] m_ctl_in,
  input  logic [DW*NM-1:0] m_dat_in,
  output logic [CW*NM-1:0] m_ctl_out,
  output logic [DW*NM-1:0] m_dat_out,
  input  logic [NS-1:0]    s_busy,
  input  logic [CW*NS-1:0] s_ctl_in,
  input  logic [DW*NS-1:0] s_dat_in,
  output logic [CW*NS-1:0] s_ctl_out,
  output logic [DW*NS-1:0] s_dat_out
);
  localparam int MW = (NM > 1) ? $clog2(NM) : 1;
  localparam int SW = (NS > 1) ? $clog2(NS) : 1;
  localparam logic [AW-2:0] NS_C = (AW-1)'(NS);
  localparam logic [1:0] IDLE = 2'b00, REQD = 2'b01, ADRD = 2'b10, GRNT = 2'b11;
  localparam logic [1:0] RQ_GO = 2'b01, RQ_END = 2'b10;

  logic [1:0]    st     [NM];
  logic [SW-1:0] sel    [NM];
  logic [MW-1:0] rr     [NS];
  logic [NM-1:0] hv     [NS];
  logic [MW-1:0] holder [NS];
  logic [MW-1:0] win    [NS];
  logic [NS-1:0] held, win_ok, give;
  logic [NM-1:0] waiting;

  always_comb begin
    int t;
    t = 0;
    for (int i = 0; i < NM; i++)
      waiting[i] = (st[i] == ADRD) && (m_req[2*i +: 2] != RQ_END);
    for (int j = 0; j < NS; j++) begin
      hv[j] = '0;
      holder[j] = '0;
      for (int i = 0; i < NM; i++)
        if (st[i] == GRNT && sel[i] == SW'(j)) begin
          hv[j][i] = 1'b1;
          holder[j] = MW'(i);
        end
      held[j] = |hv[j];
      win_ok[j] = 1'b0;
      win[j] = '0;
      for (int k = 1; k <= NM; k++) begin
        t = int'(rr[j]) + k;
        if (t >= NM) t = t - NM;
        if (!win_ok[j] && waiting[t] && sel[t] == SW'(j)) begin
          win_ok[j] = 1'b1;
          win[j] = MW'(t);
        end
      end
      give[j] = win_ok[j] && !held[j] && !s_busy[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NM; i++) begin
        st[i]  <= IDLE;
        sel[i] <= '0;
      end
      for (int j = 0; j < NS; j++) rr[j] <= MW'(NM - 1);
    end else begin
      for (int i = 0; i < NM; i++) begin
        case (st[i])
          IDLE: if (m_req[2*i +: 2] == RQ_GO) st[i] <= REQD;
          REQD:
            if (m_req[2*i +: 2] == RQ_END) st[i] <= IDLE;
            else if (m_addr[AW*i] && m_addr[AW*i+1 +: AW-1] < NS_C) begin
              st[i]  <= ADRD;
              sel[i] <= m_addr[AW*i+1 +: SW];
            end
          ADRD:
            if (m_req[2*i +: 2] == RQ_END) st[i] <= IDLE;
            else if (give[sel[i]] && win[sel[i]] == MW'(i)) st[i] <= GRNT;
          default: if (m_req[2*i +: 2] == RQ_END) st[i] <= IDLE;
        endcase
      end
      for (int j = 0; j < NS; j++)
        if (give[j]) rr[j] <= win[j];
    end
  end

  for (genvar gi = 0; gi < NM; gi++) begin : g_mst
    assign m_ack[2*gi +: 2]       = st[gi];
    assign m_ctl_out[CW*gi +: CW] = (st[gi] == GRNT) ? s_ctl_in[CW*sel[gi] +: CW] : '0;
    assign m_dat_out[DW*gi +: DW] = (st[gi] == GRNT) ? s_dat_in[DW*sel[gi] +: DW] : '0;

    assert_idle_exit_R2: assert property (@(posedge clk) disable iff (rst)
      (m_ack[2*gi +: 2] == IDLE && m_req[2*gi +: 2] != RQ_GO) |=> m_ack[2*gi +: 2] == IDLE);
    assert_bad_addr_R3: assert property (@(posedge clk) disable iff (rst)
      (m_ack[2*gi +: 2] == REQD && m_req[2*gi +: 2] != RQ_END && !m_addr[AW*gi])
        |=> m_ack[2*gi +: 2] == REQD);
    assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (rst)
      (m_ack[2*gi +: 2] == ADRD && s_busy[sel[gi]]) |=> m_ack[2*gi +: 2] != GRNT);
    assert_end_release_R7: assert property (@(posedge clk) disable iff (rst)
      (m_ack[2*gi +: 2] != IDLE && m_req[2*gi +: 2] == RQ_END) |=> m_ack[2*gi +: 2] == IDLE);
  end

  for (genvar gj = 0; gj < NS; gj++) begin : g_slv
    assign s_ctl_out[CW*gj +: CW] = held[gj] ? m_ctl_in[CW*holder[gj] +: CW] : '0;
    assign s_dat_out[DW*gj +: DW] = held[gj] ? m_dat_in[DW*holder[gj] +: DW] : '0;

    assert_single_holder_R4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hv[gj]));
  end
endmodule

// File: tb/test_bus_access_ctrl.sv
`timescale 1ns/1ps
module test_bus_access_ctrl;
  localparam int NM = 3, NS = 4, AW = 4, CW = 4, DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2*NM-1:0]  m_req = '0;
  logic [AW*NM-1:0] m_addr = '0;
  logic [2*NM-1:0]  m_ack;
  logic [CW*NM-1:0] m_ctl_in = '0;
  logic [DW*NM-1:0] m_dat_in = '0;
  logic [CW*NM-1:0] m_ctl_out;
  logic [DW*NM-1:0] m_dat_out;
  logic [NS-1:0]    s_busy = '0;
  logic [CW*NS-1:0] s_ctl_in = '0;
  logic [DW*NS-1:0] s_dat_in = '0;
  logic [CW*NS-1:0] s_ctl_out;
  logic [DW*NS-1:0] s_dat_out;

  int checks = 0, fails = 0;
  int e_st[NM], e_sel[NM], e_rr[NS];

  always #2.5 clk = ~clk;

  bus_access_ctrl #(.NM(NM), .NS(NS), .AW(AW), .CW(CW), .DW(DW)) i_bus_access_ctrl (
    .clk(clk), .rst(rst), .m_req(m_req), .m_addr(m_addr), .m_ack(m_ack),
    .m_ctl_in(m_ctl_in), .m_dat_in(m_dat_in), .m_ctl_out(m_ctl_out), .m_dat_out(m_dat_out),
    .s_busy(s_busy), .s_ctl_in(s_ctl_in), .s_dat_in(s_dat_in),
    .s_ctl_out(s_ctl_out), .s_dat_out(s_dat_out));

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ack(int i);
    return int'(m_ack[2*i +: 2]);
  endfunction

  task automatic setreq(int i, int v);
    m_req[2*i +: 2] = 2'(v);
  endtask

  task automatic setadr(int i, int code, int vld);
    m_addr[AW*i +: AW] = {3'(code), 1'(vld)};
  endtask

  task automatic model_step();
    int ns[NM], nsel[NM];
    bit hd[NS];
    bit wt[NM];
    int r, a;
    if (rst) begin
      for (int i = 0; i < NM; i++) begin e_st[i] = 0; e_sel[i] = 0; end
      for (int j = 0; j < NS; j++) e_rr[j] = NM - 1;
      return;
    end
    for (int j = 0; j < NS; j++) hd[j] = 0;
    for (int i = 0; i < NM; i++) if (e_st[i] == 3) hd[e_sel[i]] = 1;
    for (int i = 0; i < NM; i++) begin
      r = int'(m_req[2*i +: 2]);
      a = int'(m_addr[AW*i +: AW]);
      ns[i] = e_st[i];
      nsel[i] = e_sel[i];
      wt[i] = (e_st[i] == 2) && (r != 2);
      case (e_st[i])
        0: if (r == 1) ns[i] = 1;
        1: if (r == 2) ns[i] = 0;
           else if ((a & 1) == 1 && (a >> 1) < NS) begin ns[i] = 2; nsel[i] = a >> 1; end
        default: if (r == 2) ns[i] = 0;
      endcase
    end
    for (int j = 0; j < NS; j++) begin
      if (!hd[j] && !s_busy[j]) begin
        for (int k = 1; k <= NM; k++) begin
          int t;
          t = (e_rr[j] + k) % NM;
          if (wt[t] && e_sel[t] == j) begin
            ns[t] = 3;
            e_rr[j] = t;
            break;
          end
        end
      end
    end
    for (int i = 0; i < NM; i++) begin e_st[i] = ns[i]; e_sel[i] = nsel[i]; end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_route(string tag);
    for (int j = 0; j < NS; j++) begin
      int h;
      h = -1;
      for (int i = 0; i < NM; i++) if (e_st[i] == 3 && e_sel[i] == j) h = i;
      chk(tag, s_dat_out[DW*j +: DW], (h >= 0) ? longint'(m_dat_in[DW*h +: DW]) : 0);
      chk(tag, s_ctl_out[CW*j +: CW], (h >= 0) ? longint'(m_ctl_in[CW*h +: CW]) : 0);
    end
    for (int i = 0; i < NM; i++) begin
      chk(tag, m_dat_out[DW*i +: DW], (e_st[i] == 3) ? longint'(s_dat_in[DW*e_sel[i] +: DW]) : 0);
      chk(tag, m_ctl_out[CW*i +: CW], (e_st[i] == 3) ? longint'(s_ctl_in[CW*e_sel[i] +: CW]) : 0);
    end
  endtask

  task automatic rand_data();
    for (int i = 0; i < NM; i++) begin
      m_dat_in[DW*i +: DW] = DW'($urandom);
      m_ctl_in[CW*i +: CW] = CW'($urandom);
    end
    for (int j = 0; j < NS; j++) begin
      s_dat_in[DW*j +: DW] = DW'($urandom);
      s_ctl_in[CW*j +: CW] = CW'($urandom);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5eed));
    rand_data();
    tick(); tick();
    // R1 reset state, with nonzero bus inputs applied
    for (int i = 0; i < NM; i++) chk("R1 reply during reset", ack(i), 0);
    chk_route("R1 routed outputs during reset");
    rst = 1'b0;
    tick();
    for (int i = 0; i < NM; i++) chk("R1 reply after reset", ack(i), 0);
    chk_route("R1 routed outputs after reset");

    // R2 idle ignores non-request codes
    setreq(0, 3); tick(); chk("R2 code 11 ignored", ack(0), 0);
    setreq(0, 2); tick(); chk("R2 code 10 ignored", ack(0), 0);
    setreq(0, 1); tick(); chk("R2 request ack", ack(0), 1);
    setreq(0, 0);

    // R3 invalid addresses
    setadr(0, 5, 1); tick(); chk("R3 slave code 5 ignored", ack(0), 1);
    setadr(0, 7, 1); tick(); chk("R3 slave code 7 ignored", ack(0), 1);
    setadr(0, 2, 0); tick(); chk("R3 valid flag clear ignored", ack(0), 1);
    s_busy = 4'b0100;
    setadr(0, 2, 1); tick(); chk("R3 address ack", ack(0), 2);
    tick(); chk("R4 busy slave withholds grant", ack(0), 2);
    s_busy = 4'b0000;
    tick(); chk("R4 grant when free", ack(0), 3);
    for (int n = 0; n < 8; n++) begin rand_data(); #1; chk_route("R6 routing single holder"); end

    // R4 held slave, R7 release timing
    setreq(1, 1); tick(); chk("R2 second master request", ack(1), 1);
    setreq(1, 0); setadr(1, 2, 1); tick(); chk("R3 second master address", ack(1), 2);
    tick(); chk("R4 held slave withholds grant", ack(1), 2);
    chk_route("R6 waiting master sees zeros");
    setreq(0, 2); tick();
    chk("R7 end returns to idle", ack(0), 0);
    chk("R7 no grant in release cycle", ack(1), 2);
    setreq(0, 0); tick(); chk("R7 released slave granted next", ack(1), 3);
    chk_route("R6 routing after handover");

    // R5 rotation on slave 2 (master 1 last granted)
    setadr(0, 2, 1); setadr(2, 2, 1);
    setreq(0, 1); setreq(2, 1); tick();
    setreq(0, 0); setreq(2, 0); tick();
    chk("R5 m0 waiting", ack(0), 2); chk("R5 m2 waiting", ack(2), 2);
    setreq(1, 2); tick(); chk("R7 m1 released", ack(1), 0);
    setreq(1, 0); tick();
    chk("R5 m2 wins after m1", ack(2), 3); chk("R5 m0 keeps waiting", ack(0), 2);
    setreq(1, 1); tick(); setreq(1, 0); tick(); chk("R5 m1 waiting again", ack(1), 2);
    setreq(2, 2); tick(); setreq(2, 0); tick();
    chk("R5 m0 wins after m2", ack(0), 3); chk("R5 m1 still waits", ack(1), 2);
    setreq(0, 2); tick(); setreq(0, 0); tick();
    chk("R5 m1 wins after m0", ack(1), 3);
    setreq(1, 2); tick(); setreq(1, 0);
    chk("R7 m1 idle", ack(1), 0);

    // R4 parallel grants on different slaves
    setadr(0, 0, 1); setadr(1, 3, 1);
    setreq(0, 1); setreq(1, 1); tick();
    setreq(0, 0); setreq(1, 0); tick(); tick();
    chk("R4 parallel grant m0", ack(0), 3); chk("R4 parallel grant m1", ack(1), 3);
    for (int n = 0; n < 8; n++) begin rand_data(); #1; chk_route("R6 routing two holders"); end
    setreq(0, 2); setreq(1, 2); tick(); setreq(0, 0); setreq(1, 0);
    chk("R7 both released m0", ack(0), 0); chk("R7 both released m1", ack(1), 0);

    // R7 end code from request-acknowledged state
    setreq(2, 1); tick(); chk("R2 m2 request", ack(2), 1);
    setreq(2, 2); setadr(2, 1, 1); tick(); chk("R7 end beats address capture", ack(2), 0);

    // R8 reset while granted
    setreq(2, 1); tick(); setreq(2, 0); tick(); tick();
    chk("R4 m2 granted slave 1", ack(2), 3);
    rst = 1'b1; tick();
    for (int i = 0; i < NM; i++) chk("R8 reset from grant", ack(i), 0);
    chk_route("R8 routes cleared by reset");
    rst = 1'b0; tick();

    // constrained random phase against the bench model
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < NM; i++) begin
        int r;
        r = int'($urandom % 16);
        setreq(i, (r < 9) ? 0 : (r < 13) ? 1 : (r < 15) ? 2 : 3);
        m_addr[AW*i +: AW] = AW'($urandom);
      end
      for (int j = 0; j < NS; j++) s_busy[j] = ($urandom % 4) == 0;
      rand_data();
      if (($urandom % 500) == 0) rst = 1'b1; else rst = 1'b0;
      tick();
      for (int i = 0; i < NM; i++) chk("R4 random reply", ack(i), e_st[i]);
      chk_route("R6 random routing");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule